// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O

This block places three 8-bit general-purpose ports, named A, B and C, behind a small bus. The bus has an 8-bit data path, a two-bit register select, and three active-low strobes: chip select, read and write. Each port pin is modelled as three signals: an output value, an output enable, and an input sample. This lets the block sit in front of a pad ring or a bidirectional pin wrapper.

Software configures the ports through one write-only control register, and the top bit of each word written there gives it one of two meanings:
- With the top bit set, the word defines the directions. Ports A and B each take a direction, and so do the upper and lower nibbles of port C.
- With the top bit clear, the word sets or clears one chosen port C line and leaves the others alone.

Only the basic latched mode is supported. Outputs hold the last value written. Reads of an input return the live pins.

Top module: `pio3_top`

## Requirements
- R1: After reset, every output enable is 0, every output latch is 0, and all four port halves are inputs.
- R2: Register select 0 addresses port A, 1 port B, 2 port C and 3 the control register.
- R3: A control write with bit 7 = 1, bits 6:5 = 0 and bit 2 = 0 sets the directions. The fields are bit 4 for port A, bit 1 for port B, bit 3 for C[7:4] and bit 0 for C[3:0], where 1 means input. An output half drives all of its enables to 1 and an input half drives them to 0.
- R4: An accepted direction write clears all output latches of A, B and C to 0 in the same clock edge that applies the new directions.
- R5: A control write with bit 7 = 1 but a nonzero value in bits 6:5 or bit 2 changes neither directions nor latches.
- R6: A control write with bit 7 = 0 sets port C line index bits 3:1 to the value in bit 0. The other port C lines do not change, and bits 6:4 are ignored.
- R7: A data write loads the whole latch of the selected port, and the latch holds that value until the next write that touches it.
- R8: A read of a port returns the live input pins for halves configured as input and the latch contents for halves configured as output. Port C is resolved per nibble.
- R9: A read of the control address returns 0x00.
- R10: No write takes effect while chip select is high.
- R11: Read data enable is high only while chip select and read are both low and write is high. While the enable is low, read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low, sampled on the clock edge |
| addr_i | input | 2 | Register select |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data enable |
| pa_i | input | 8 | Port A pin samples |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin samples |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin samples |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C output enables |

## Verification
The assertions assume that the host never drives the read and write strobes low together. The block treats that case as neither a read nor a write, and the checks on latch behaviour take one bus cycle per edge for granted. The bench's bus tasks lower one strobe at a time, and they raise it again on the next falling clock edge before any other access starts. Pin inputs change only between bus accesses, so a live-pin read never races a pin update.

// File: rtl/pio3_pkg.sv
package pio3_pkg;
  localparam int unsigned CW_FLAG = 7;
  localparam int unsigned CW_A_IN = 4;
  localparam int unsigned CW_CU_IN = 3;
  localparam int unsigned CW_B_IN = 1;
  localparam int unsigned CW_CL_IN = 0;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_cfg_t;
endpackage

// File: rtl/pio3_decode.sv
module pio3_decode
  import pio3_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [1:0]       addr_i,
  input  logic [W-1:0]     data_i,
  output logic             rd_act_o,
  output reg_sel_e         rd_sel_o,
  output logic             wr_a_o,
  output logic             wr_b_o,
  output logic             wr_c_o,
  output logic             mode_set_o,
  output dir_cfg_t         mode_cfg_o,
  output logic             bsr_en_o,
  output logic [IDX_W-1:0] bsr_idx_o,
  output logic             bsr_val_o
);
  logic     wr_act;
  logic     ctrl_wr;
  logic     mode_ok;
  reg_sel_e sel;

  assign sel      = reg_sel_e'(addr_i);
  assign rd_act_o = !cs_ni && !rd_ni && wr_ni;
  assign wr_act   = !cs_ni && !wr_ni && rd_ni;
  assign rd_sel_o = sel;

  assign wr_a_o  = wr_act && (sel == SEL_A);
  assign wr_b_o  = wr_act && (sel == SEL_B);
  assign wr_c_o  = wr_act && (sel == SEL_C);
  assign ctrl_wr = wr_act && (sel == SEL_CTRL);

  // only basic mode accepted: both mode fields must be zero
  assign mode_ok    = (data_i[6:5] == 2'b00) && !data_i[2];
  assign mode_set_o = ctrl_wr && data_i[CW_FLAG] && mode_ok;
  assign mode_cfg_o = '{a_in:  data_i[CW_A_IN],
                        b_in:  data_i[CW_B_IN],
                        cu_in: data_i[CW_CU_IN],
                        cl_in: data_i[CW_CL_IN]};

  assign bsr_en_o  = ctrl_wr && !data_i[CW_FLAG];
  assign bsr_idx_o = data_i[IDX_W:1];
  assign bsr_val_o = data_i[0];
endmodule

// File: rtl/pio3_port.sv
module pio3_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] wdata_i,
  input  logic         is_in_i,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (clear_i) q_q <= '0;
    else              q_q <= (q_q & ~wmask_i) | (wdata_i & wmask_i);
  end

  assign q_o     = q_q;
  assign oe_o    = {W{!is_in_i}};
  assign rdata_o = is_in_i ? pins_i : q_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (q_o == '0)); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && wmask_i == '0) |=> $stable(q_o)); // R7
endmodule

// File: rtl/pio3_top.sv
module pio3_top
  import pio3_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [1:0]        addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o
);
  localparam int unsigned HALF_W = PORT_W / 2;
  localparam int unsigned IDX_W  = $clog2(PORT_W);

  logic             rd_act;
  reg_sel_e         rd_sel;
  logic             wr_a, wr_b, wr_c;
  logic             mode_set;
  dir_cfg_t         mode_cfg;
  logic             bsr_en;
  logic [IDX_W-1:0] bsr_idx;
  logic             bsr_val;
  dir_cfg_t         cfg_q;
  logic [PORT_W-1:0] bsr_mask;
  logic [PORT_W-1:0] ra, rb, rc;

  pio3_decode #(.W(PORT_W), .IDX_W(IDX_W)) u_dec (
    .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni), .addr_i(addr_i), .data_i(data_i),
    .rd_act_o(rd_act), .rd_sel_o(rd_sel),
    .wr_a_o(wr_a), .wr_b_o(wr_b), .wr_c_o(wr_c),
    .mode_set_o(mode_set), .mode_cfg_o(mode_cfg),
    .bsr_en_o(bsr_en), .bsr_idx_o(bsr_idx), .bsr_val_o(bsr_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
    else if (mode_set) cfg_q <= mode_cfg;
  end

  always_comb begin
    bsr_mask = '0;
    if (bsr_en) bsr_mask[bsr_idx] = 1'b1;
  end

  pio3_port #(.W(PORT_W)) u_pa (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(mode_set),
    .wmask_i({PORT_W{wr_a}}), .wdata_i(data_i), .is_in_i(cfg_q.a_in),
    .pins_i(pa_i), .q_o(pa_o), .oe_o(pa_oe_o), .rdata_o(ra)
  );

  pio3_port #(.W(PORT_W)) u_pb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(mode_set),
    .wmask_i({PORT_W{wr_b}}), .wdata_i(data_i), .is_in_i(cfg_q.b_in),
    .pins_i(pb_i), .q_o(pb_o), .oe_o(pb_oe_o), .rdata_o(rb)
  );

  for (genvar h = 0; h < 2; h++) begin : g_pc
    logic [HALF_W-1:0] msk, dat;
    logic              in_sel;
    assign in_sel = (h == 0) ? cfg_q.cl_in : cfg_q.cu_in;
    assign msk    = wr_c ? {HALF_W{1'b1}} : bsr_mask[h*HALF_W +: HALF_W];
    assign dat    = wr_c ? data_i[h*HALF_W +: HALF_W] : {HALF_W{bsr_val}};
    pio3_port #(.W(HALF_W)) u_half (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(mode_set),
      .wmask_i(msk), .wdata_i(dat), .is_in_i(in_sel),
      .pins_i(pc_i[h*HALF_W +: HALF_W]), .q_o(pc_o[h*HALF_W +: HALF_W]),
      .oe_o(pc_oe_o[h*HALF_W +: HALF_W]), .rdata_o(rc[h*HALF_W +: HALF_W])
    );
  end

  always_comb begin
    data_o = '0;
    if (rd_act) begin
      unique case (rd_sel)
        SEL_A:   data_o = ra;
        SEL_B:   data_o = rb;
        SEL_C:   data_o = rc;
        default: data_o = '0;
      endcase
    end
  end
  assign data_oe_o = rd_act;

  AST_OE_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pa_oe_o == '0 || pa_oe_o == '1) && (pb_oe_o == '0 || pb_oe_o == '1)); // R3
  AST_MODE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_set |=> (pa_o == '0 && pb_o == '0 && pc_o == '0)); // R4
  AST_BAD_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !wr_ni && rd_ni && addr_i == 2'd3 && data_i[7] && (data_i[6:5] != 2'b00 || data_i[2]))
      |=> ($stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o) && $stable(pc_o))); // R5
  AST_BSR_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_en |=> ($countones(pc_o ^ $past(pc_o)) <= 1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> ($stable(pa_o) && $stable(pb_o) && $stable(pc_o) && $stable(pc_oe_o))); // R10
  AST_CTRL_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && addr_i == 2'd3) |-> (data_o == '0)); // R9
  AST_RD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0)); // R11
endmodule

// File: tb/tb_pio3_top.sv
module tb_pio3_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o, pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;
  logic       data_oe_o;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pio3_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe_o),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe_o),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cs_ni = 1'b0; wr_ni = 1'b0; addr_i = a; data_i = d;
    @(negedge clk_i);
    cs_ni = 1'b1; wr_ni = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic en);
    @(negedge clk_i);
    cs_ni = 1'b0; rd_ni = 1'b0; addr_i = a;
    #1;
    d = data_o; en = data_oe_o;
    @(negedge clk_i);
    cs_ni = 1'b1; rd_ni = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic en;
    chk("R1 pa_oe", pa_oe_o, 8'h00);
    chk("R1 pb_oe", pb_oe_o, 8'h00);
    chk("R1 pc_oe", pc_oe_o, 8'h00);
    chk("R1 pc_o", pc_o, 8'h00);
    chk("R11 idle data", data_o, 8'h00);
    chk("R11 idle en", {7'd0, data_oe_o}, 8'h00);
    bus_rd(2'd3, d, en);
    chk("R9 ctrl read", d, 8'h00);
    chk("R11 read en", {7'd0, en}, 8'h01);
  endtask

  task automatic t_all_out();
    logic [7:0] d; logic en;
    bus_wr(2'd3, 8'h80);
    chk("R3 pa_oe out", pa_oe_o, 8'hFF);
    chk("R3 pc_oe out", pc_oe_o, 8'hFF);
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'h96);
    chk("R2 R7 pa_o", pa_o, 8'h5A);
    chk("R2 R7 pb_o", pb_o, 8'hC3);
    chk("R2 R7 pc_o", pc_o, 8'h96);
    pa_i = 8'h00;
    bus_rd(2'd0, d, en);
    chk("R8 read A latch", d, 8'h5A);
    bus_rd(2'd1, d, en);
    chk("R8 read B latch", d, 8'hC3);
  endtask

  task automatic t_mixed();
    logic [7:0] d; logic en;
    bus_wr(2'd3, 8'h8A); // A out, B in, C upper in, C lower out
    chk("R3 pa_oe", pa_oe_o, 8'hFF);
    chk("R3 pb_oe", pb_oe_o, 8'h00);
    chk("R3 pc_oe", pc_oe_o, 8'h0F);
    chk("R4 pa cleared", pa_o, 8'h00);
    chk("R4 pb cleared", pb_o, 8'h00);
    chk("R4 pc cleared", pc_o, 8'h00);
    pb_i = 8'h3C; pc_i = 8'hA5;
    bus_wr(2'd2, 8'hFF);
    chk("R7 pc latch", pc_o, 8'hFF);
    bus_rd(2'd2, d, en);
    chk("R8 C mixed read", d, 8'hAF);
    bus_rd(2'd1, d, en);
    chk("R8 B live pins", d, 8'h3C);
    pb_i = 8'h81;
    bus_rd(2'd1, d, en);
    chk("R8 B follows pins", d, 8'h81);
  endtask

  task automatic t_bsr();
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h0B); // line 5 set
    chk("R6 set line5", pc_o, 8'h20);
    bus_wr(2'd3, 8'h01); // line 0 set
    chk("R6 set line0", pc_o, 8'h21);
    bus_wr(2'd3, 8'h7F); // line 7 set, bits 6:4 junk
    chk("R6 set line7 ignore 6:4", pc_o, 8'hA1);
    bus_wr(2'd3, 8'h0A); // line 5 clear
    chk("R6 clear line5", pc_o, 8'h81);
    chk("R6 oe unchanged", pc_oe_o, 8'hFF);
  endtask

  task automatic t_bad_mode();
    bus_wr(2'd3, 8'h84);
    chk("R5 pc_oe kept", pc_oe_o, 8'hFF);
    chk("R5 pc_o kept", pc_o, 8'h81);
    bus_wr(2'd3, 8'hBF);
    chk("R5 pa_oe kept", pa_oe_o, 8'hFF);
    chk("R5 pc_o still kept", pc_o, 8'h81);
  endtask

  task automatic t_cs_gate();
    @(negedge clk_i);
    cs_ni = 1'b1; wr_ni = 1'b0; addr_i = 2'd0; data_i = 8'hEE;
    @(negedge clk_i);
    wr_ni = 1'b1;
    chk("R10 pa_o unchanged", pa_o, 8'h00);
    @(negedge clk_i);
    cs_ni = 1'b1; wr_ni = 1'b0; addr_i = 2'd3; data_i = 8'h9B;
    @(negedge clk_i);
    wr_ni = 1'b1;
    chk("R10 dirs unchanged", pa_oe_o, 8'hFF);
    @(negedge clk_i);
    rd_ni = 1'b0; addr_i = 2'd2;
    #1;
    chk("R11 no cs data", data_o, 8'h00);
    chk("R11 no cs en", {7'd0, data_oe_o}, 8'h00);
    rd_ni = 1'b1;
  endtask

  task automatic t_hold();
    bus_wr(2'd0, 8'h11);
    repeat (5) @(negedge clk_i);
    chk("R7 hold", pa_o, 8'h11);
    bus_wr(2'd0, 8'h22);
    chk("R7 overwrite", pa_o, 8'h22);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_all_out();
    t_mixed();
    t_bsr();
    t_bad_mode();
    t_cs_gate();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule